// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block is a parameterised storage register, eight bits wide by default, that updates on the rising clock edge. A two-bit mode input picks one of four operations each cycle: keep the contents, shift toward the high end, shift toward the low end, or capture a parallel word. An active-low clear input forces every bit to zero at the next edge, whatever the mode.

Parallel data uses a single shared bus. The stored word drives the bus through a tri-state stage, and load data arrives on the same wires. For synthesis the bus is split into an input port, an output port and a drive-enable port. The drive enable is combinational. It drops when either of two active-low enables is high, and it also drops by itself whenever load mode is selected, so another agent can drive the load word.

The lowest and highest stored bits also leave on dedicated serial outputs. These are always driven, so a longer chain can be built by wiring one register's high serial output into the next register's low serial input.

Top module: `usr_shift_reg`

## Requirements
- R1: With clr_n high and mode 2'b11, the register takes bus_in at the rising edge, so bit n of bus_in becomes stored bit n.
- R2: With clr_n high and mode 2'b01, the new word is {old[W-2:0], ser_in_lo}: ser_in_lo enters bit 0 and each bit moves one place up.
- R3: With clr_n high and mode 2'b10, the new word is {ser_in_hi, old[W-1:1]}: ser_in_hi enters bit W-1 and each bit moves one place down.
- R4: While clr_n is low at a rising edge, all stored bits become 0 regardless of mode. The clear has no effect between edges.
- R5: With clr_n high and mode 2'b00, the stored word is unchanged.
- R6: bus_oe is 0 whenever oe_a_n or oe_b_n is 1.
- R7: bus_oe is 0 whenever mode is 2'b11, in the same cycle the mode is applied.
- R8: bus_oe is 1 when oe_a_n and oe_b_n are both 0 and mode is not 2'b11. bus_out always carries the stored word.
- R9: ser_out_lo equals stored bit 0 and ser_out_hi equals stored bit W-1 at all times, whatever the output enables are.
- R10: Load, shift, hold and clear keep working while bus_oe is 0.
- R11: Two instances chained high serial output to low serial input form a 2W-bit shift-right register, with the first instance holding the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low; takes priority over mode |
| mode | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 parallel load |
| oe_a_n | input | 1 | Bus drive enable, active low |
| oe_b_n | input | 1 | Second bus drive enable, active low |
| ser_in_lo | input | 1 | Serial bit entering bit 0 on shift up |
| ser_in_hi | input | 1 | Serial bit entering bit W-1 on shift down |
| bus_in | input | W | Shared bus, receive side (load data) |
| bus_out | output | W | Shared bus, drive side (stored word) |
| bus_oe | output | 1 | Tri-state drive enable for bus_out |
| ser_out_lo | output | 1 | Stored bit 0, always driven |
| ser_out_hi | output | 1 | Stored bit W-1, always driven |

## Verification
The hardest case to reach from the ports is the register changing state while the bus is released, because the stored word cannot be seen on the bus then. The stimulus holds one enable high, loads and shifts, and watches the always-driven serial end bits. It then re-enables the bus and reads back the word to confirm the shifts took effect. A second instance chained through the serial pins checks a 16-bit shift across the seam against a reference word kept in the bench.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_next.sv
module usr_next
  import usr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clr_n,
  input  logic [1:0]   mode,
  input  logic         ser_in_lo,
  input  logic         ser_in_hi,
  input  logic [W-1:0] bus_in,
  input  logic [W-1:0] q,
  output logic [W-1:0] d,
  output logic         en
);
  logic [W-1:0] from_below;
  logic [W-1:0] from_above;

  assign from_below = {q[W-2:0], ser_in_lo};
  assign from_above = {ser_in_hi, q[W-1:1]};

  // clock enable: idle only when holding and not clearing
  assign en = !clr_n || (usr_mode_e'(mode) != MODE_HOLD);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      if (!clr_n) begin
        d[i] = 1'b0;
      end else begin
        unique case (usr_mode_e'(mode))
          MODE_LOAD: d[i] = bus_in[i];
          MODE_UP:   d[i] = from_below[i];
          MODE_DOWN: d[i] = from_above[i];
          default:   d[i] = q[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/usr_bus_ctl.sv
module usr_bus_ctl
  import usr_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       oe_a_n,
  input  logic       oe_b_n,
  output logic       bus_oe
);
  logic load_sel;

  assign load_sel = (usr_mode_e'(mode) == MODE_LOAD);
  // release the bus for incoming load data even if enables are active
  assign bus_oe   = !oe_a_n && !oe_b_n && !load_sel;
endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
  import usr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [1:0]   mode,
  input  logic         oe_a_n,
  input  logic         oe_b_n,
  input  logic         ser_in_lo,
  input  logic         ser_in_hi,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  output logic         ser_out_lo,
  output logic         ser_out_hi
);
  localparam int MSB = W - 1;

  logic [W-1:0] q;
  logic [W-1:0] q_d;
  logic         q_en;

  usr_next #(.W(W)) next_i (
    .clr_n     (clr_n),
    .mode      (mode),
    .ser_in_lo (ser_in_lo),
    .ser_in_hi (ser_in_hi),
    .bus_in    (bus_in),
    .q         (q),
    .d         (q_d),
    .en        (q_en)
  );

  always_ff @(posedge clk) begin
    if (q_en) begin
      q <= q_d;
    end
  end

  usr_bus_ctl bus_ctl_i (
    .mode   (mode),
    .oe_a_n (oe_a_n),
    .oe_b_n (oe_b_n),
    .bus_oe (bus_oe)
  );

  assign bus_out    = q;
  assign ser_out_lo = q[0];
  assign ser_out_hi = q[MSB];

  assert_clear_R4: assert property (@(posedge clk)
    !clr_n |=> (q == '0));

  assert_load_R1: assert property (@(posedge clk) disable iff (!clr_n)
    (usr_mode_e'(mode) == MODE_LOAD) |=> (q == $past(bus_in)));

  assert_shift_up_R2: assert property (@(posedge clk) disable iff (!clr_n)
    (usr_mode_e'(mode) == MODE_UP) |=> (q == {$past(q[MSB-1:0]), $past(ser_in_lo)}));

  assert_shift_down_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (usr_mode_e'(mode) == MODE_DOWN) |=> (q == {$past(ser_in_hi), $past(q[MSB:1])}));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (usr_mode_e'(mode) == MODE_HOLD) |=> $stable(q));

  assert_enable_off_R6: assert property (@(posedge clk)
    (oe_a_n || oe_b_n) |-> !bus_oe);

  assert_bus_release_R7: assert property (@(posedge clk)
    (usr_mode_e'(mode) == MODE_LOAD) |-> !bus_oe);
endmodule

// File: tb/usr_shift_reg_tb_top.sv
`timescale 1ns/1ps
module usr_shift_reg_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clr_n;
  logic [1:0]   mode;
  logic         oe_a_n, oe_b_n;
  logic         ser_in_lo, ser_in_hi;
  logic [W-1:0] bus_in, bus_in2;
  logic [W-1:0] bus_out, bus_out2;
  logic         bus_oe, bus_oe2;
  logic         ser_out_lo, ser_out_hi;
  logic         ser_out_lo2, ser_out_hi2;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  usr_shift_reg #(.W(W)) dut_i (
    .clk(clk), .clr_n(clr_n), .mode(mode), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .ser_in_lo(ser_in_lo), .ser_in_hi(ser_in_hi), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .ser_out_lo(ser_out_lo), .ser_out_hi(ser_out_hi)
  );

  // second stage of the chain: fed from the first stage's high serial output
  usr_shift_reg #(.W(W)) casc_i (
    .clk(clk), .clr_n(clr_n), .mode(mode), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .ser_in_lo(ser_out_hi), .ser_in_hi(1'b0), .bus_in(bus_in2),
    .bus_out(bus_out2), .bus_oe(bus_oe2), .ser_out_lo(ser_out_lo2), .ser_out_hi(ser_out_hi2)
  );

  // vector: {clr_n, mode[1:0], ser_in_lo, ser_in_hi, bus_in[7:0], expected word[7:0]}
  localparam int NV = 13;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 2'b11, 1'b0, 1'b0, 8'hAA, 8'h00},
    {1'b1, 2'b11, 1'b0, 1'b0, 8'hA5, 8'hA5},
    {1'b1, 2'b01, 1'b1, 1'b0, 8'h00, 8'h4B},
    {1'b1, 2'b01, 1'b0, 1'b0, 8'h00, 8'h96},
    {1'b1, 2'b10, 1'b0, 1'b1, 8'h00, 8'hCB},
    {1'b1, 2'b10, 1'b0, 1'b0, 8'h00, 8'h65},
    {1'b1, 2'b00, 1'b1, 1'b1, 8'hFF, 8'h65},
    {1'b0, 2'b01, 1'b1, 1'b1, 8'h00, 8'h00},
    {1'b1, 2'b11, 1'b0, 1'b0, 8'h80, 8'h80},
    {1'b1, 2'b10, 1'b0, 1'b0, 8'h00, 8'h40},
    {1'b1, 2'b00, 1'b0, 1'b0, 8'h00, 8'h40},
    {1'b1, 2'b11, 1'b0, 1'b0, 8'h7E, 8'h7E},
    {1'b0, 2'b00, 1'b0, 1'b0, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on the falling edge, let one rising edge pass, sample on the next falling edge
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] ref_word;
    logic [15:0] pattern;
    string tag;
    clr_n = 1'b0; mode = 2'b00; oe_a_n = 1'b0; oe_b_n = 1'b0;
    ser_in_lo = 1'b0; ser_in_hi = 1'b0; bus_in = '0; bus_in2 = '0;
    @(negedge clk);

    // table walk: vector 0 is the reset-state check
    for (int v = 0; v < NV; v++) begin
      {clr_n, mode, ser_in_lo, ser_in_hi, bus_in} = VEC[v][20:8];
      if (!clr_n) tag = "R4";
      else case (mode)
        2'b11:   tag = "R1";
        2'b01:   tag = "R2";
        2'b10:   tag = "R3";
        default: tag = "R5";
      endcase
      cycle();
      mode = 2'b00; clr_n = 1'b1;
      #1;
      chk(tag, {8'h00, bus_out}, {8'h00, VEC[v][7:0]});
      chk("R9", {14'h0, ser_out_hi, ser_out_lo}, {14'h0, VEC[v][7], VEC[v][0]});
    end

    // bus enable decoding, same-cycle response
    mode = 2'b00; oe_a_n = 1'b0; oe_b_n = 1'b0; #1;
    chk("R8", {15'h0, bus_oe}, 16'h1);
    oe_a_n = 1'b1; #1;
    chk("R6", {15'h0, bus_oe}, 16'h0);
    oe_a_n = 1'b0; oe_b_n = 1'b1; #1;
    chk("R6", {15'h0, bus_oe}, 16'h0);
    oe_b_n = 1'b0; mode = 2'b11; #1;
    chk("R7", {15'h0, bus_oe}, 16'h0);
    mode = 2'b01; #1;
    chk("R8", {15'h0, bus_oe}, 16'h1);

    // operation with the bus released: watch serial pins, read back later
    @(negedge clk);
    oe_a_n = 1'b1; mode = 2'b11; bus_in = 8'h81;
    cycle();
    mode = 2'b00; #1;
    chk("R10", {15'h0, bus_oe}, 16'h0);
    chk("R9", {14'h0, ser_out_hi, ser_out_lo}, 16'h3);
    mode = 2'b01; ser_in_lo = 1'b0;
    cycle();
    mode = 2'b00; #1;
    chk("R9", {14'h0, ser_out_hi, ser_out_lo}, 16'h0);
    mode = 2'b10; ser_in_hi = 1'b1;
    cycle();
    mode = 2'b00; ser_in_hi = 1'b0; oe_a_n = 1'b0; #1;
    chk("R10", {7'h0, bus_oe, bus_out}, {7'h0, 1'b1, 8'h81});
    oe_b_n = 1'b1; clr_n = 1'b0;
    cycle();
    clr_n = 1'b1; oe_b_n = 1'b0; #1;
    chk("R10", {8'h0, bus_out}, 16'h0000);

    // chained pair: 16-bit shift toward the high end
    mode = 2'b11; bus_in = 8'h3C; bus_in2 = 8'hC3;
    cycle();
    ref_word = 16'hC33C;
    mode = 2'b00; #1;
    chk("R11", {bus_out2, bus_out}, ref_word);
    pattern = 16'b1011_0010_1110_0101;
    for (int k = 0; k < 16; k++) begin
      mode = 2'b01; ser_in_lo = pattern[k];
      cycle();
      ref_word = {ref_word[14:0], pattern[k]};
      mode = 2'b00; #1;
      chk("R11", {bus_out2, bus_out}, ref_word);
    end
    chk("R11", {bus_out2, bus_out}, {pattern[0], pattern[1], pattern[2], pattern[3],
        pattern[4], pattern[5], pattern[6], pattern[7], pattern[8], pattern[9],
        pattern[10], pattern[11], pattern[12], pattern[13], pattern[14], pattern[15]});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule